// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

An eight-stage register (width set by a parameter) with four operating modes, picked by a two-bit select: hold, shift toward the high stage, shift toward the low stage, and parallel load. A single bidirectional data port does two jobs. In load mode the port is an input and the block lets go of it so that outside logic can drive it. In the other modes the port is a tri-state output that shows the register contents. Two active-low enables gate that output. Shifting, loading and clearing do not depend on those enables.

Each shift direction has its own serial input. Two serial outputs are always driven and show the two end stages. An active-low clear sets every stage to zero and wins over any mode selection. An elaboration parameter decides whether the clear acts at once (asynchronous) or at the next rising edge (synchronous). A synchronous active-high reset also zeros the register. A separate `data_out` bus always shows the stored value, and `port_oe` shows when the block is driving the shared port.

Top module: `bidir_shift_reg`

## Requirements
- R1: With `mode_sel` = 2'b00 and clear inactive, the stored value does not change across a rising edge.
- R2: With `mode_sel` = 2'b01, a rising edge moves every stage i (1..W-1) to take the old value of stage i-1, and stage 0 takes `ser_right_in`.
- R3: With `mode_sel` = 2'b10, a rising edge moves every stage i (0..W-2) to take the old value of stage i+1, and stage W-1 takes `ser_left_in`.
- R4: With `mode_sel` = 2'b11, a rising edge stores the value present on `port_io`. In this mode `port_oe` is 0 and the block does not drive `port_io`, whatever the enables are.
- R5: If `oe_a_n` or `oe_b_n` is 1, `port_oe` is 0 and `port_io` carries whatever outside logic drives. If both are 0 and the mode is not load, `port_oe` is 1.
- R6: Shifting, loading and clearing behave the same while the port is disabled by the enables.
- R7: `clear_n` = 0 forces every stage to 0 and takes priority over every mode. With SYNC_CLEAR = 1 the register clears at the next rising edge. With SYNC_CLEAR = 0 it clears at once, without waiting for the clock.
- R8: While `clear_n` = 0 and the port is enabled (not load mode), `port_io` shows all zeros. In load mode the port stays released.
- R9: `ser_low_out` always equals stage 0 and `ser_high_out` always equals stage W-1. Both are driven at all times.
- R10: `data_out` always equals the stored value, whether or not the port is enabled.
- R11: `rst` = 1 at a rising edge zeros the register. After reset, `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_n | input | 1 | Active-low clear (sync or async per SYNC_CLEAR) |
| mode_sel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_right_in | input | 1 | Serial data entering stage 0 in mode 01 |
| ser_left_in | input | 1 | Serial data entering stage W-1 in mode 10 |
| oe_a_n | input | 1 | Active-low port enable, first |
| oe_b_n | input | 1 | Active-low port enable, second |
| port_io | inout | W | Shared parallel load input / tri-state output |
| data_out | output | W | Stored value, always driven |
| port_oe | output | 1 | 1 while the block drives port_io |
| ser_low_out | output | 1 | Stage 0 value |
| ser_high_out | output | 1 | Stage W-1 value |

## Verification
The embedded properties check every cycle that each mode produces its next state from the previous cycle's state and inputs. They also check that the port is released in load mode and whenever either enable is high, and that clear and reset leave the register at zero one edge later. Only the bench's scenarios can show a few things. One is that the block never drives the port while the bench does. Another is that a disabled port still carries the bench's value back. A third is that a clear shows zeros on the port before the synchronous edge. The last is the contrast between the two clear variants inside a single clock period.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/bsr_next.sv
`timescale 1ns/1ps
// Next-state selection, one mux per stage built by generate.
module bsr_next #(
  parameter int W = 8
) (
  input  logic [W-1:0]   cur_q,
  input  bsr_pkg::mode_e mode,
  input  logic           sr_in,
  input  logic           sl_in,
  input  logic [W-1:0]   load_val,
  output logic [W-1:0]   nxt_q
);
  import bsr_pkg::*;

  localparam int TOP = W - 1;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_low_end
      assign from_low = sr_in;
    end else begin : g_low_mid
      assign from_low = cur_q[i-1];
    end
    if (i == TOP) begin : g_high_end
      assign from_high = sl_in;
    end else begin : g_high_mid
      assign from_high = cur_q[i+1];
    end
    assign nxt_q[i] = (mode == MODE_SHR)  ? from_low  :
                      (mode == MODE_SHL)  ? from_high :
                      (mode == MODE_LOAD) ? load_val[i] :
                                            cur_q[i];
  end
endmodule

// File: rtl/bsr_storage.sv
`timescale 1ns/1ps
// State flops; SYNC_CLEAR picks the clear flavour.
module bsr_storage #(
  parameter int W          = 8,
  parameter bit SYNC_CLEAR = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_n,
  input  logic [W-1:0] nxt_q,
  output logic [W-1:0] q
);
  if (SYNC_CLEAR) begin : g_sync_clr
    always_ff @(posedge clk) begin
      if (rst || !clear_n) q <= '0;
      else                 q <= nxt_q;
    end
  end else begin : g_async_clr
    always_ff @(posedge clk or negedge clear_n) begin
      if (!clear_n)  q <= '0;
      else if (rst)  q <= '0;
      else           q <= nxt_q;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    !clear_n |=> (q == '0)); // R7
  AST_RESET_ZEROES: assert property (@(posedge clk)
    rst |=> (q == '0)); // R11
endmodule

// File: rtl/bsr_port_ctrl.sv
`timescale 1ns/1ps
// Output-enable and drive-value control of the shared port.
module bsr_port_ctrl #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           oe_a_n,
  input  logic           oe_b_n,
  input  bsr_pkg::mode_e mode,
  input  logic           clear_n,
  input  logic [W-1:0]   q,
  output logic           oe,
  output logic [W-1:0]   drive_val
);
  import bsr_pkg::*;

  logic enables_on;
  assign enables_on = !oe_a_n && !oe_b_n;
  assign oe         = enables_on && (mode != MODE_LOAD);
  assign drive_val  = clear_n ? q : '0;

  AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LOAD) |-> !oe); // R4
  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (rst)
    (oe_a_n || oe_b_n) |-> !oe); // R5
  AST_CLEAR_SHOWS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!clear_n && oe) |-> (drive_val == '0)); // R8
endmodule

// File: rtl/bidir_shift_reg.sv
`timescale 1ns/1ps
module bidir_shift_reg #(
  parameter int W          = 8,
  parameter bit SYNC_CLEAR = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_n,
  input  logic [1:0]   mode_sel,
  input  logic         ser_right_in,
  input  logic         ser_left_in,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  inout  wire  [W-1:0] port_io,
  output logic [W-1:0] data_out,
  output logic         port_oe,
  output logic         ser_low_out,
  output logic         ser_high_out
);
  import bsr_pkg::*;

  localparam int TOP = W - 1;

  mode_e        mode;
  logic [W-1:0] q;
  logic [W-1:0] nxt_q;
  logic [W-1:0] drive_val;
  logic [W-1:0] load_val;

  assign mode     = mode_e'(mode_sel);
  assign load_val = port_io;

  bsr_next #(.W(W)) u_next (
    .cur_q    (q),
    .mode     (mode),
    .sr_in    (ser_right_in),
    .sl_in    (ser_left_in),
    .load_val (load_val),
    .nxt_q    (nxt_q)
  );

  bsr_storage #(.W(W), .SYNC_CLEAR(SYNC_CLEAR)) u_store (
    .clk     (clk),
    .rst     (rst),
    .clear_n (clear_n),
    .nxt_q   (nxt_q),
    .q       (q)
  );

  bsr_port_ctrl #(.W(W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .oe_a_n    (oe_a_n),
    .oe_b_n    (oe_b_n),
    .mode      (mode),
    .clear_n   (clear_n),
    .q         (q),
    .oe        (port_oe),
    .drive_val (drive_val)
  );

  assign port_io      = port_oe ? drive_val : 'z;
  assign data_out     = q;
  assign ser_low_out  = q[0];
  assign ser_high_out = q[TOP];

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (clear_n && mode_sel == 2'b00) |=> (!clear_n || $stable(data_out))); // R1
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
    (clear_n && mode_sel == 2'b01) |=>
      (!clear_n || data_out == {$past(data_out[W-2:0]), $past(ser_right_in)})); // R2
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (clear_n && mode_sel == 2'b10) |=>
      (!clear_n || data_out == {$past(ser_left_in), $past(data_out[W-1:1])})); // R3
  AST_LOAD_TAKES_PORT: assert property (@(posedge clk) disable iff (rst)
    (clear_n && mode_sel == 2'b11) |=> (!clear_n || data_out == $past(port_io))); // R4
endmodule

// File: tb/bidir_shift_reg_bench.sv
`timescale 1ns/1ps
module bidir_shift_reg_bench;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] q;
    string        tag;
  } exp_item_t;

  logic         clk = 1'b0;
  logic         rst;
  logic         clear_n;
  logic [1:0]   mode_sel;
  logic         sr, sl;
  logic         ena_n, enb_n;
  logic         drv_en;
  logic [W-1:0] drv_val;
  wire  [W-1:0] port_s;
  wire  [W-1:0] port_a;
  logic [W-1:0] dout_s, dout_a;
  logic         oe_s, oe_a;
  logic         lo_s, hi_s, lo_a, hi_a;

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] model_q;
  exp_item_t    exp_q[$];

  always #2.5 clk = ~clk;

  assign port_s = drv_en ? drv_val : 'z;
  assign port_a = drv_en ? drv_val : 'z;

  bidir_shift_reg #(.W(W), .SYNC_CLEAR(1'b1)) u_bidir_shift_reg (
    .clk(clk), .rst(rst), .clear_n(clear_n), .mode_sel(mode_sel),
    .ser_right_in(sr), .ser_left_in(sl), .oe_a_n(ena_n), .oe_b_n(enb_n),
    .port_io(port_s), .data_out(dout_s), .port_oe(oe_s),
    .ser_low_out(lo_s), .ser_high_out(hi_s)
  );

  bidir_shift_reg #(.W(W), .SYNC_CLEAR(1'b0)) u_bidir_shift_reg_async (
    .clk(clk), .rst(rst), .clear_n(clear_n), .mode_sel(mode_sel),
    .ser_right_in(sr), .ser_left_in(sl), .oe_a_n(ena_n), .oe_b_n(enb_n),
    .port_io(port_a), .data_out(dout_a), .port_oe(oe_a),
    .ser_low_out(lo_a), .ser_high_out(hi_a)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, predict the state, queue it.
  task automatic step(input logic [1:0] s, input logic r, input logic l,
                      input logic c, input logic [W-1:0] d, input logic de,
                      input string tag);
    mode_sel = s; sr = r; sl = l; clear_n = c; drv_val = d; drv_en = de;
    if (rst || !c)        model_q = '0;
    else case (s)
      2'b01:   model_q = {model_q[W-2:0], r};
      2'b10:   model_q = {l, model_q[W-1:1]};
      2'b11:   model_q = d;
      default: model_q = model_q;
    endcase
    @(posedge clk);
    #1;
    exp_q.push_back('{q: model_q, tag: tag});
  endtask

  // Monitor: compare registered outputs, watch for port contention.
  always @(negedge clk) begin
    if (drv_en && (oe_s || oe_a))
      check(1'b0, "R4/R5 contention", {oe_s, oe_a}, 0);
    if (exp_q.size() > 0) begin
      exp_item_t e;
      e = exp_q.pop_front();
      check(dout_s == e.q, {e.tag, " R10 data_out"}, dout_s, e.q);
      check(lo_s == e.q[0] && hi_s == e.q[W-1], {e.tag, " R9 serial taps"},
            {hi_s, lo_s}, {e.q[W-1], e.q[0]});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WATCHDOG", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; clear_n = 1'b1; mode_sel = 2'b00; sr = 1'b0; sl = 1'b0;
    ena_n = 1'b0; enb_n = 1'b0; drv_en = 1'b0; drv_val = '0; model_q = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    check(dout_s == '0 && dout_a == '0, "R11 reset state", dout_s, 0);
    check(oe_s == 1'b1 && port_s == '0, "R5 enabled port drives", {oe_s, port_s}, 9'h100);

    // R4: load through the released port
    mode_sel = 2'b11; drv_en = 1'b1; drv_val = 8'hA5; #1;
    check(oe_s == 1'b0 && port_s == 8'hA5, "R4 port released in load", port_s, 8'hA5);
    step(2'b11, 0, 0, 1, 8'hA5, 1, "R4 load");
    step(2'b00, 0, 0, 1, 8'h00, 0, "R1 hold");
    step(2'b00, 1, 1, 1, 8'h00, 0, "R1 hold serial ignored");
    #1 check(port_s == 8'hA5, "R5 port shows register", port_s, 8'hA5);

    // R2 / R3: shifts with mixed serial data
    step(2'b01, 1, 0, 1, 0, 0, "R2 shift up");
    step(2'b01, 0, 1, 1, 0, 0, "R2 shift up");
    step(2'b01, 1, 1, 1, 0, 0, "R2 shift up");
    step(2'b10, 0, 1, 1, 0, 0, "R3 shift down");
    step(2'b10, 1, 0, 1, 0, 0, "R3 shift down");
    step(2'b10, 0, 1, 1, 0, 0, "R3 shift down");
    step(2'b10, 1, 1, 1, 0, 0, "R3 shift down");

    // R5 / R6: disabled port, operation continues
    ena_n = 1'b1; mode_sel = 2'b00; drv_en = 1'b1; drv_val = 8'h3C; #1;
    check(oe_s == 1'b0 && port_s == 8'h3C, "R5 enable A high releases", port_s, 8'h3C);
    step(2'b01, 1, 0, 1, 8'h3C, 1, "R6 shift while disabled");
    ena_n = 1'b0; enb_n = 1'b1; #1;
    check(oe_s == 1'b0 && port_s == 8'h3C, "R5 enable B high releases", port_s, 8'h3C);
    step(2'b11, 0, 0, 1, 8'h96, 1, "R6 load while disabled");
    step(2'b10, 0, 0, 1, 8'h96, 1, "R6 shift down while disabled");
    enb_n = 1'b0; drv_en = 1'b0; mode_sel = 2'b00; #1;
    check(oe_s == 1'b1 && port_s == model_q, "R5 re-enabled drives", port_s, model_q);

    // R8 / R7: synchronous clear, priority over shift
    mode_sel = 2'b01; clear_n = 1'b0; #1;
    check(port_s == '0 && dout_s == model_q, "R8 clear shows zeros before edge",
          {dout_s, port_s}, {model_q, 8'h00});
    step(2'b01, 1, 1, 0, 0, 0, "R7 sync clear beats shift");
    mode_sel = 2'b11; drv_en = 1'b1; drv_val = 8'h5A; #1;
    check(oe_s == 1'b0 && port_s == 8'h5A, "R8 clear in load keeps released", port_s, 8'h5A);
    step(2'b11, 0, 0, 0, 8'h5A, 1, "R7 clear beats load");

    // R7: asynchronous variant clears without waiting for the clock
    step(2'b11, 0, 0, 1, 8'hFF, 1, "R4 load ones");
    step(2'b00, 0, 0, 1, 8'h00, 0, "R1 hold ones");
    clear_n = 1'b0; #1;
    check(dout_a == '0, "R7 async clear immediate", dout_a, 0);
    check(dout_s == 8'hFF, "R7 sync clear waits for edge", dout_s, 8'hFF);
    step(2'b00, 0, 0, 0, 0, 0, "R7 clear settles");
    #1 check(dout_a == '0, "R7 async variant zero", dout_a, 0);

    // R11: reset mid-run
    step(2'b11, 0, 0, 1, 8'hC3, 1, "R4 load before reset");
    rst = 1'b1;
    step(2'b11, 0, 0, 1, 8'h11, 1, "R11 reset beats load");
    rst = 1'b0;
    step(2'b01, 1, 0, 1, 0, 0, "R2 shift after reset");

    drv_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule